// File: doc/BRIEF.md
# Power-Management Event Interrupt Controller

This block gathers up to seven wake-up or status events from a power-management unit and reports them to a parent interrupt controller on a single level-sensitive line. Each event input is captured into a pending register. A separate enable register selects which pending bits may drive the combined line. The line stays high while any pending bit is also enabled.

Software reaches both registers over a plain 32-bit register port made of address, write enable, write data and registered read data. The pending register is ordinary read/write storage. Writing a 0 clears a bit and writing a 1 sets it, which raises that interrupt. Because of this, a read-modify-write clear can drop an event that lands between the read and the write. The hardware narrows that window: an event that arrives in the same cycle as the write is never lost.

There is no data stream in this block, so every pin is a plain control or status signal and there is no valid/ready handshake.

Top module: `pmu_irq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the pending and enable registers hold zero, `irq_o` is low and `reg_rdata` is zero.
- R2: An event input that is high at a rising clock edge sets its pending bit, whatever the enable bit is. The bit stays set after the input returns low and until software writes a 0 to it.
- R3: A write at byte offset 0x00 loads pending bits 6..0 from `reg_wdata[6:0]`. A written 0 clears a bit and a written 1 sets it.
- R4: When a write at offset 0x00 and an event hit the same bit in the same cycle, the bit ends up set.
- R5: A write at byte offset 0x04 loads enable bits 6..0 from `reg_wdata[6:0]`, where 1 enables a source. Writing 0 to offset 0x04 and then 0 to offset 0x00, with no events, leaves nothing enabled and nothing pending.
- R6: `irq_o` is high exactly when (pending AND enable) is non-zero. It follows a register change in the same cycle the register changes, with no extra delay.
- R7: `reg_rdata` has one cycle of latency. In the cycle after an address is presented, it shows that register as it stood before the clock edge. Pending is at offset 0x00 and enable at offset 0x04, zero-extended to 32 bits.
- R8: Data bits 31..7 read as zero and ignore writes. A read of any other offset returns zero, and a write to any other offset changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 7 | Event inputs, one per source; high at an edge sets the pending bit |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_we | input | 1 | Write enable, sampled on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the address presented one cycle earlier |
| irq_o | output | 1 | Combined level interrupt to the parent controller |

## Verification
Pending and enable updates take effect on the edge where the event or write is sampled. `irq_o` reflects those updates in the same cycle, after that edge. `reg_rdata` is due one edge after its address and carries the register values from before that edge. The bench drives inputs on the falling edge. At the next falling edge it compares both outputs against a behavioural model that is advanced on every rising edge. Each result is therefore checked exactly one edge after the stimulus, and read data lags by that same single register.

// File: rtl/pmu_irq_pkg.sv
package pmu_irq_pkg;
  localparam int unsigned SRC_CNT_DEF  = 7;
  localparam int unsigned DATA_W_DEF   = 32;
  localparam int unsigned ADDR_W_DEF   = 8;
  localparam int unsigned OFF_PEND_DEF = 0;
  localparam int unsigned OFF_ENA_DEF  = 4;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PEND = 2'd1,
    SEL_ENA  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/pmu_irq_decode.sv
module pmu_irq_decode
  import pmu_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = ADDR_W_DEF,
  parameter int unsigned OFF_PEND = OFF_PEND_DEF,
  parameter int unsigned OFF_ENA  = OFF_ENA_DEF
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFF_PEND);
  localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(OFF_ENA);

  always_comb begin
    if (addr == A_PEND)     sel = SEL_PEND;
    else if (addr == A_ENA) sel = SEL_ENA;
    else                    sel = SEL_NONE;
  end
endmodule

// File: rtl/pmu_irq_pending.sv
module pmu_irq_pending #(
  parameter int unsigned SRC_CNT = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SRC_CNT-1:0] evt_i,
  input  logic               wr_en,
  input  logic [SRC_CNT-1:0] wr_bits,
  output logic [SRC_CNT-1:0] pend_q
);
  for (genvar i = 0; i < SRC_CNT; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_q[i] <= 1'b0;
      else if (evt_i[i]) pend_q[i] <= 1'b1;
      else if (wr_en)    pend_q[i] <= wr_bits[i];
    end
  end
endmodule

// File: rtl/pmu_irq_enable.sv
module pmu_irq_enable #(
  parameter int unsigned SRC_CNT = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SRC_CNT-1:0] wr_bits,
  output logic [SRC_CNT-1:0] ena_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ena_q <= '0;
    else if (wr_en) ena_q <= wr_bits;
  end
endmodule

// File: rtl/pmu_irq_rdback.sv
module pmu_irq_rdback
  import pmu_irq_pkg::*;
#(
  parameter int unsigned SRC_CNT = 7,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  reg_sel_e           sel,
  input  logic [SRC_CNT-1:0] pend_q,
  input  logic [SRC_CNT-1:0] ena_q,
  output logic [DATA_W-1:0]  rdata
);
  logic [DATA_W-1:0] rd_nxt;

  always_comb begin
    rd_nxt = '0;
    case (sel)
      SEL_PEND: rd_nxt[SRC_CNT-1:0] = pend_q;
      SEL_ENA:  rd_nxt[SRC_CNT-1:0] = ena_q;
      default:  rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_nxt;
  end
endmodule

// File: rtl/pmu_irq_ctrl.sv
module pmu_irq_ctrl
  import pmu_irq_pkg::*;
#(
  parameter int unsigned SRC_CNT  = SRC_CNT_DEF,
  parameter int unsigned DATA_W   = DATA_W_DEF,
  parameter int unsigned ADDR_W   = ADDR_W_DEF,
  parameter int unsigned OFF_PEND = OFF_PEND_DEF,
  parameter int unsigned OFF_ENA  = OFF_ENA_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SRC_CNT-1:0] evt_i,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_we,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq_o
);
  reg_sel_e           sel;
  logic [SRC_CNT-1:0] pend_q;
  logic [SRC_CNT-1:0] ena_q;
  logic [SRC_CNT-1:0] wr_bits;
  logic               wr_pend;
  logic               wr_ena;

  assign wr_bits = reg_wdata[SRC_CNT-1:0];
  assign wr_pend = reg_we && (sel == SEL_PEND);
  assign wr_ena  = reg_we && (sel == SEL_ENA);

  pmu_irq_decode #(
    .ADDR_W(ADDR_W), .OFF_PEND(OFF_PEND), .OFF_ENA(OFF_ENA)
  ) u_dec (
    .addr(reg_addr), .sel(sel)
  );

  pmu_irq_pending #(.SRC_CNT(SRC_CNT)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .wr_en(wr_pend), .wr_bits(wr_bits), .pend_q(pend_q)
  );

  pmu_irq_enable #(.SRC_CNT(SRC_CNT)) u_ena (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_ena), .wr_bits(wr_bits), .ena_q(ena_q)
  );

  pmu_irq_rdback #(.SRC_CNT(SRC_CNT), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .sel(sel),
    .pend_q(pend_q), .ena_q(ena_q), .rdata(reg_rdata)
  );

  assign irq_o = |(pend_q & ena_q);
endmodule

// File: rtl/pmu_irq_chk.sv
module pmu_irq_chk #(
  parameter int unsigned SRC_CNT  = 7,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned OFF_PEND = 0,
  parameter int unsigned OFF_ENA  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [SRC_CNT-1:0] evt_i,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic               reg_we,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic               irq_o,
  input logic [SRC_CNT-1:0] pend_q,
  input logic [SRC_CNT-1:0] ena_q
);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFF_PEND);
  localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(OFF_ENA);

  AST_EVT_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((pend_q & $past(evt_i)) == $past(evt_i))); // R2
  AST_PEND_ONLY_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_PEND) |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R2
  AST_PEND_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_PEND) |=> (pend_q == ($past(reg_wdata[SRC_CNT-1:0]) | $past(evt_i)))); // R3
  AST_EVT_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_PEND && evt_i != '0) |=> ((pend_q & $past(evt_i)) == $past(evt_i))); // R4
  AST_ENA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_ENA) |=> (ena_q == $past(reg_wdata[SRC_CNT-1:0]))); // R5
  AST_ENA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_ENA) |=> $stable(ena_q)); // R8
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !reg_we) |=> irq_o); // R6
  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(reg_we) || (($past(evt_i) & ena_q) != '0))); // R6
  AST_RD_PEND_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_PEND) |=> (reg_rdata[SRC_CNT-1:0] == $past(pend_q))); // R7
  AST_RD_ENA_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_ENA) |=> (reg_rdata[SRC_CNT-1:0] == $past(ena_q))); // R7
  AST_RD_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != A_PEND && reg_addr != A_ENA) |=> (reg_rdata == '0)); // R8
  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[DATA_W-1:SRC_CNT] == '0)); // R8
endmodule

bind pmu_irq_ctrl pmu_irq_chk #(
  .SRC_CNT(SRC_CNT), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .OFF_PEND(OFF_PEND), .OFF_ENA(OFF_ENA)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_addr(reg_addr),
  .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .irq_o(irq_o), .pend_q(pend_q), .ena_q(ena_q)
);

// File: tb/pmu_irq_ctrl_test.sv
module pmu_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  evt_i = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  string tag = "R1";

  // behavioural reference state
  int m_pend = 0;
  int m_ena = 0;
  int m_rd = 0;

  always #5 clk = ~clk;

  pmu_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_ena = 0; m_rd = 0;
    end else begin
      if (reg_addr == 8'h00)      m_rd = m_pend;
      else if (reg_addr == 8'h04) m_rd = m_ena;
      else                        m_rd = 0;
      if (reg_we && reg_addr == 8'h00) m_pend = int'(reg_wdata) & 'h7f;
      m_pend = m_pend | int'(evt_i);
      if (reg_we && reg_addr == 8'h04) m_ena = int'(reg_wdata) & 'h7f;
    end
  end

  task automatic compare();
    int exp_irq;
    exp_irq = ((m_pend & m_ena) != 0) ? 1 : 0;
    total++;
    if (int'(irq_o) != exp_irq) begin
      bad++;
      $display("FAIL %s/R6 irq_o actual=%0d expected=%0d at %0t", tag, irq_o, exp_irq, $time);
    end
    total++;
    if (reg_rdata != 32'(m_rd)) begin
      bad++;
      $display("FAIL %s/R7 reg_rdata actual=%08h expected=%08h at %0t", tag, reg_rdata, m_rd, $time);
    end
  endtask

  task automatic step(input logic [6:0] e, input logic [7:0] a, input logic w, input logic [31:0] d);
    @(negedge clk);
    compare();
    evt_i = e; reg_addr = a; reg_we = w; reg_wdata = d;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    tag = "R1";
    repeat (3) step(7'h00, 8'h00, 1'b0, 32'h0);
    rst_n = 1'b1;
    step(7'h00, 8'h00, 1'b0, 32'h0);
    step(7'h00, 8'h04, 1'b0, 32'h0);
    step(7'h00, 8'h00, 1'b0, 32'h0);
    // R2: masked pulse still latched and stays
    tag = "R2";
    step(7'h08, 8'h00, 1'b0, 32'h0);
    step(7'h00, 8'h00, 1'b0, 32'h0);
    step(7'h00, 8'h00, 1'b0, 32'h0);
    // R5/R6: enabling a latched source raises irq
    tag = "R5";
    step(7'h00, 8'h04, 1'b1, 32'h08);
    step(7'h00, 8'h04, 1'b0, 32'h0);
    step(7'h00, 8'h00, 1'b0, 32'h0);
    // R3: write 0 clears, write 1 sets
    tag = "R3";
    step(7'h00, 8'h00, 1'b1, 32'h0);
    step(7'h00, 8'h00, 1'b1, 32'h41);
    step(7'h00, 8'h00, 1'b0, 32'h0);
    step(7'h00, 8'h04, 1'b1, 32'h7f);
    step(7'h00, 8'h00, 1'b0, 32'h0);
    // R4: clear write collides with event on bit 2
    tag = "R4";
    step(7'h04, 8'h00, 1'b1, 32'h0);
    step(7'h00, 8'h00, 1'b0, 32'h0);
    step(7'h00, 8'h00, 1'b0, 32'h0);
    // R8: upper bits and unmapped offsets
    tag = "R8";
    step(7'h00, 8'h00, 1'b1, 32'hffff_ff80);
    step(7'h00, 8'h00, 1'b1, 32'hffff_ffff);
    step(7'h00, 8'h08, 1'b1, 32'h0);
    step(7'h00, 8'h01, 1'b1, 32'h0);
    step(7'h00, 8'hfc, 1'b1, 32'h0);
    step(7'h00, 8'h00, 1'b0, 32'h0);
    step(7'h00, 8'h04, 1'b1, 32'hffff_ff00);
    step(7'h00, 8'h08, 1'b0, 32'h0);
    step(7'h00, 8'h04, 1'b0, 32'h0);
    step(7'h00, 8'h02, 1'b0, 32'h0);
    // R7: mixed traffic
    tag = "R7";
    for (int i = 0; i < 400; i++) begin
      logic [6:0] e;
      logic [7:0] a;
      int pick;
      e = ($urandom_range(0, 3) == 0) ? 7'(1 << $urandom_range(0, 6)) : 7'h00;
      pick = $urandom_range(0, 3);
      a = (pick == 0) ? 8'h00 : (pick == 1) ? 8'h04 : (pick == 2) ? 8'h08 : 8'h05;
      step(e, a, ($urandom_range(0, 2) == 0), $urandom());
    end
    // R5: disable-then-clear sequence leaves nothing pending
    tag = "R5";
    step(7'h00, 8'h04, 1'b1, 32'h0);
    step(7'h00, 8'h00, 1'b1, 32'h0);
    step(7'h00, 8'h00, 1'b0, 32'h0);
    step(7'h00, 8'h04, 1'b0, 32'h0);
    step(7'h00, 8'h00, 1'b0, 32'h0);
    @(negedge clk);
    compare();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule